// File: doc/BRIEF.md
# Memory Bit Test-and-Set Unit

This block performs an atomic single-bit test-and-set on byte-addressed memory. It receives a decoded instruction as two 16-bit halfwords. It reads its operands through two combinational register-file read ports. It fetches the target byte, then writes the byte back with the chosen bit forced high. Before the write it updates a zero flag. The flag takes the inverse of the bit's earlier value, so software can tell whether it won a lock or semaphore bit.

Two encodings are accepted. The immediate form takes its 3-bit bit number from the instruction. It forms the address from a base register plus a sign-extended 16-bit displacement. The register form takes the address directly from one register, and the bit number from the low three bits of a second register. The unit owns the memory port from the read until the write-back finishes. It signals this with `busy`. With a memory that answers at once, one instruction takes three clocks: the issue cycle, the read cycle and the write cycle.

Top module: `bit_tas_unit`

## Requirements
- R1: After reset, `busy`, `mem_req`, `mem_we`, `zflag_we` and `z_flag` are all 0.
- R2: Immediate form: `issue_hw0[15:14]` = 2'b00 and `issue_hw0[10:5]` = 6'b111110. The bit number is `issue_hw0[13:11]`. The base register index is `issue_hw0[4:0]`. The address is that register's value plus `issue_hw1` sign-extended to 32 bits.
- R3: Register form: `issue_hw0[10:5]` = 6'b111111 and `issue_hw1` = 16'h00E0. The address is the value of register `issue_hw0[4:0]`. The bit number is bits 2:0 of register `issue_hw0[15:11]`, and its upper bits are ignored.
- R4: The zero flag `z_flag` takes the inverse of the addressed bit as read. `zflag_we` pulses high for exactly one cycle, the cycle after the read handshake completes.
- R5: The write-back goes to the same address as the read. Its data is the read byte with the selected bit set to 1 and every other bit unchanged.
- R6: An accepted instruction raises `busy` and a read request on the next cycle. With `mem_ready` held high, `busy` lasts exactly 2 cycles. Each memory wait state adds one cycle.
- R7: The read always comes before the write, and each instruction makes exactly one read and one write. While `mem_req` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` hold steady.
- R8: `issue_valid` is ignored while `busy` is high, and also when neither encoding matches. An ignored issue causes no memory access and no flag update.
- R9: `z_flag` changes only in a cycle where `zflag_we` is high, and keeps its value between instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | Instruction halfwords are valid this cycle |
| issue_hw0 | input | 16 | First instruction halfword |
| issue_hw1 | input | 16 | Second instruction halfword (displacement or fixed extension) |
| busy | output | 1 | Read-modify-write sequence in progress |
| rf_idx_a | output | 5 | Register index for address operand (`issue_hw0[4:0]`) |
| rf_data_a | input | 32 | Register value for index `rf_idx_a`, same cycle |
| rf_idx_b | output | 5 | Register index for bit-select operand (`issue_hw0[15:11]`) |
| rf_data_b | input | 32 | Register value for index `rf_idx_b`, same cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ready | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 8 | Read byte, valid when `mem_ready` is high on a read |
| zflag_we | output | 1 | Zero-flag update strobe |
| z_flag | output | 1 | Zero flag value |

## Verification
The assertions assume that `mem_rdata` is valid in the cycle where a read completes with `mem_ready`, since the write-back and flag checks compare against that byte one cycle later. They also assume the register ports answer in the same cycle, and that `mem_ready` only matters while `mem_req` is high. The bench memory model keeps to these rules. It drives read data combinationally from its array at `mem_addr`, raises `mem_ready` only during a request after a per-test count of wait cycles, and commits writes at the edge of the completing handshake.

// File: rtl/bts_pkg.sv
package bts_pkg;

  localparam int XLEN    = 32;
  localparam int HW_W    = 16;
  localparam int RIDX_W  = 5;
  localparam int BSEL_W  = 3;
  localparam int BYTE_W  = 1 << BSEL_W;
  localparam int SUBOP_W = 6;

  localparam logic [SUBOP_W-1:0] SUBOP_IMM  = 6'b111110;
  localparam logic [SUBOP_W-1:0] SUBOP_REG  = 6'b111111;
  localparam logic [1:0]         IMM_TOP    = 2'b00;
  localparam logic [HW_W-1:0]    REG_EXT_HW = 16'h00E0;

  typedef enum logic [1:0] {
    FORM_NONE = 2'd0,
    FORM_IMM  = 2'd1,
    FORM_REG  = 2'd2
  } form_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;

  function automatic logic [XLEN-1:0] sext_disp(input logic [HW_W-1:0] d);
    return {{(XLEN-HW_W){d[HW_W-1]}}, d};
  endfunction

  function automatic logic [BYTE_W-1:0] bit_mask(input logic [BSEL_W-1:0] b);
    return BYTE_W'(1) << b;
  endfunction

  function automatic logic test_bit(input logic [BYTE_W-1:0] v,
                                    input logic [BSEL_W-1:0] b);
    return |(v & bit_mask(b));
  endfunction

  function automatic logic [BYTE_W-1:0] set_bit(input logic [BYTE_W-1:0] v,
                                                input logic [BSEL_W-1:0] b);
    return v | bit_mask(b);
  endfunction

endpackage

// File: rtl/bts_decode.sv
module bts_decode
  import bts_pkg::*;
(
  input  logic [HW_W-1:0]   hw0,
  input  logic [HW_W-1:0]   hw1,
  output form_e             form,
  output logic [RIDX_W-1:0] idx_a,
  output logic [RIDX_W-1:0] idx_b,
  output logic [BSEL_W-1:0] imm_bit,
  output logic [HW_W-1:0]   disp
);

  localparam int SUB_LO = RIDX_W;
  localparam int SUB_HI = RIDX_W + SUBOP_W - 1;
  localparam int B_LO   = SUB_HI + 1;
  localparam int B_HI   = B_LO + BSEL_W - 1;

  logic [SUBOP_W-1:0] subop;
  logic               is_imm;
  logic               is_reg;

  assign subop   = hw0[SUB_HI:SUB_LO];
  assign idx_a   = hw0[RIDX_W-1:0];
  assign idx_b   = hw0[HW_W-1:HW_W-RIDX_W];
  assign imm_bit = hw0[B_HI:B_LO];
  assign disp    = hw1;

  assign is_imm = (hw0[HW_W-1:B_HI+1] == IMM_TOP) && (subop == SUBOP_IMM);
  assign is_reg = (subop == SUBOP_REG) && (hw1 == REG_EXT_HW);

  always_comb begin
    if (is_imm)      form = FORM_IMM;
    else if (is_reg) form = FORM_REG;
    else             form = FORM_NONE;
  end

endmodule

// File: rtl/bts_agen.sv
module bts_agen
  import bts_pkg::*;
(
  input  form_e             form,
  input  logic [XLEN-1:0]   val_a,
  input  logic [XLEN-1:0]   val_b,
  input  logic [BSEL_W-1:0] imm_bit,
  input  logic [HW_W-1:0]   disp,
  output logic [XLEN-1:0]   addr,
  output logic [BSEL_W-1:0] bitn
);

  always_comb begin
    if (form == FORM_REG) begin
      addr = val_a;
      bitn = val_b[BSEL_W-1:0];
    end else begin
      addr = val_a + sext_disp(disp);
      bitn = imm_bit;
    end
  end

endmodule

// File: rtl/bts_seq.sv
module bts_seq
  import bts_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [XLEN-1:0]   addr_in,
  input  logic [BSEL_W-1:0] bit_in,
  input  logic              mem_ready,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [XLEN-1:0]   mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              zflag_we,
  output logic              z_flag,
  output logic [BSEL_W-1:0] bit_q,
  output logic              rd_done,
  output logic              wr_done
);

  seq_state_e        state_q;
  logic [XLEN-1:0]   addr_q;
  logic [BYTE_W-1:0] data_q;
  logic              zwe_q;

  assign busy      = (state_q != ST_IDLE);
  assign mem_req   = busy;
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
  assign zflag_we  = zwe_q;
  assign rd_done   = (state_q == ST_READ)  && mem_ready;
  assign wr_done   = (state_q == ST_WRITE) && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      bit_q   <= '0;
      data_q  <= '0;
      zwe_q   <= 1'b0;
      z_flag  <= 1'b0;
    end else begin
      zwe_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q  <= addr_in;
            bit_q   <= bit_in;
            state_q <= ST_READ;
          end
        end
        ST_READ: begin
          if (rd_done) begin
            data_q  <= set_bit(mem_rdata, bit_q);
            z_flag  <= ~test_bit(mem_rdata, bit_q);
            zwe_q   <= 1'b1;
            state_q <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (wr_done) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bit_tas_unit.sv
module bit_tas_unit
  import bts_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [HW_W-1:0]   issue_hw0,
  input  logic [HW_W-1:0]   issue_hw1,
  output logic              busy,
  output logic [RIDX_W-1:0] rf_idx_a,
  input  logic [XLEN-1:0]   rf_data_a,
  output logic [RIDX_W-1:0] rf_idx_b,
  input  logic [XLEN-1:0]   rf_data_b,
  output logic              mem_req,
  output logic              mem_we,
  output logic [XLEN-1:0]   mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              zflag_we,
  output logic              z_flag
);

  form_e             form;
  logic [BSEL_W-1:0] imm_bit;
  logic [HW_W-1:0]   disp;
  logic [XLEN-1:0]   tgt_addr;
  logic [BSEL_W-1:0] tgt_bit;
  logic [BSEL_W-1:0] bit_q;
  logic              legal;
  logic              accept;
  logic              rd_done;
  logic              wr_done;

  bts_decode u_dec (
    .hw0     (issue_hw0),
    .hw1     (issue_hw1),
    .form    (form),
    .idx_a   (rf_idx_a),
    .idx_b   (rf_idx_b),
    .imm_bit (imm_bit),
    .disp    (disp)
  );

  bts_agen u_agen (
    .form    (form),
    .val_a   (rf_data_a),
    .val_b   (rf_data_b),
    .imm_bit (imm_bit),
    .disp    (disp),
    .addr    (tgt_addr),
    .bitn    (tgt_bit)
  );

  assign legal  = (form != FORM_NONE);
  assign accept = issue_valid && legal && !busy;

  bts_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .addr_in   (tgt_addr),
    .bit_in    (tgt_bit),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .zflag_we  (zflag_we),
    .z_flag    (z_flag),
    .bit_q     (bit_q),
    .rd_done   (rd_done),
    .wr_done   (wr_done)
  );

endmodule

// File: rtl/bts_chk.sv
module bts_chk
  import bts_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              issue_valid,
  input logic              legal,
  input logic              accept,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [XLEN-1:0]   mem_addr,
  input logic [BYTE_W-1:0] mem_wdata,
  input logic [BYTE_W-1:0] mem_rdata,
  input logic              zflag_we,
  input logic              z_flag,
  input logic [BSEL_W-1:0] bit_q
);

  // R6
  start_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && mem_req && !mem_we);

  // R7
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ready |=> mem_req && mem_we);

  // R7
  wr_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ready |=> !busy);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata));

  // R5
  wb_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> mem_wdata == ($past(mem_rdata) | (BYTE_W'(1) << bit_q)));

  // R4
  zval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zflag_we |-> z_flag == ((($past(mem_rdata) >> bit_q) & BYTE_W'(1)) == '0));

  // R4
  zpulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zflag_we |-> $rose(mem_we));

  // R9
  zhold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !zflag_we |-> $stable(z_flag));

  // R8
  bad_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && !legal && !busy |=> !busy && !mem_req);

endmodule

bind bit_tas_unit bts_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_valid (issue_valid),
  .legal       (legal),
  .accept      (accept),
  .busy        (busy),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_ready   (mem_ready),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mem_rdata   (mem_rdata),
  .zflag_we    (zflag_we),
  .z_flag      (z_flag),
  .bit_q       (bit_q)
);

// File: tb/tb_bit_tas_unit.sv
module tb_bit_tas_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [15:0] issue_hw0 = '0;
  logic [15:0] issue_hw1 = '0;
  logic        busy;
  logic [4:0]  rf_idx_a, rf_idx_b;
  logic [31:0] rf_data_a, rf_data_b;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        zflag_we, z_flag;

  always #2.5 clk = ~clk;

  logic [31:0] regs [32];
  logic [7:0]  mem  [256];
  int          wait_cur = 0;
  int          wcnt = 0;

  assign rf_data_a = regs[rf_idx_a];
  assign rf_data_b = regs[rf_idx_b];
  assign mem_rdata = mem[mem_addr[7:0]];
  assign mem_ready = mem_req && (wcnt == wait_cur);

  always @(posedge clk) begin
    if (mem_req) begin
      if (wcnt == wait_cur) begin
        wcnt <= 0;
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  bit_tas_unit dut (
    .clk (clk), .rst_n (rst_n),
    .issue_valid (issue_valid), .issue_hw0 (issue_hw0), .issue_hw1 (issue_hw1),
    .busy (busy),
    .rf_idx_a (rf_idx_a), .rf_data_a (rf_data_a),
    .rf_idx_b (rf_idx_b), .rf_data_b (rf_data_b),
    .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
    .mem_wdata (mem_wdata), .mem_ready (mem_ready), .mem_rdata (mem_rdata),
    .zflag_we (zflag_we), .z_flag (z_flag)
  );

  int errors = 0;
  int checks = 0;

  int          rd_cnt, wr_cnt, zwe_cnt, addr_bad, order_bad;
  logic [31:0] exp_addr_g;
  logic [7:0]  last_wdata;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_addr != exp_addr_g) addr_bad++;
      if (mem_req && mem_ready) begin
        if (mem_we) begin
          if (rd_cnt != 1) order_bad++;
          wr_cnt++;
          last_wdata = mem_wdata;
        end else begin
          rd_cnt++;
        end
      end
      if (zflag_we) zwe_cnt++;
    end
  end

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon(input logic [31:0] ea);
    rd_cnt = 0; wr_cnt = 0; zwe_cnt = 0; addr_bad = 0; order_bad = 0;
    exp_addr_g = ea;
  endtask

  function automatic logic [15:0] hw_imm(input logic [2:0] b, input logic [4:0] r1);
    return {2'b00, b, 6'b111110, r1};
  endfunction

  function automatic logic [15:0] hw_reg(input logic [4:0] r2, input logic [4:0] r1);
    return {r2, 6'b111111, r1};
  endfunction

  typedef struct packed {
    logic        is_reg;
    logic [4:0]  r1;
    logic [4:0]  r2;
    logic [2:0]  ibit;
    logic [15:0] disp;
    logic [31:0] base;
    logic [31:0] sel;
    logic [7:0]  init;
    logic [1:0]  wt;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 5'd3,  5'd0,  3'd0, 16'h0010, 32'h1000_0020, 32'h0,         8'h00, 2'd0},
    '{1'b0, 5'd7,  5'd0,  3'd7, 16'hFFF0, 32'h0000_0200, 32'h0,         8'h80, 2'd0},
    '{1'b0, 5'd1,  5'd0,  3'd5, 16'h7FFF, 32'h0000_0000, 32'h0,         8'hDF, 2'd1},
    '{1'b0, 5'd31, 5'd0,  3'd3, 16'h8000, 32'h0001_0000, 32'h0,         8'h55, 2'd2},
    '{1'b1, 5'd4,  5'd9,  3'd0, 16'h0000, 32'h0000_0040, 32'h0000_0006, 8'h0F, 2'd0},
    '{1'b1, 5'd10, 5'd11, 3'd0, 16'h0000, 32'h1234_56A1, 32'hFFFF_FFFA, 8'h04, 2'd1},
    '{1'b1, 5'd12, 5'd13, 3'd0, 16'h0000, 32'h0000_0077, 32'h0000_0008, 8'hFE, 2'd3},
    '{1'b0, 5'd2,  5'd0,  3'd1, 16'h0000, 32'h0000_0055, 32'h0,         8'hFF, 2'd0}
  };

  task automatic issue(input logic [15:0] h0, input logic [15:0] h1);
    issue_hw0 = h0; issue_hw1 = h1; issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 100) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc;
    logic [31:0] ea;
    logic [2:0]  eb;
    logic [7:0]  ewb;
    logic        z_keep;
    for (int i = 0; i < 32; i++) regs[i] = 32'h0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    clear_mon(32'h0);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy",    {31'd0, busy},     32'd0);
    check("R1 mem_req", {31'd0, mem_req},  32'd0);
    check("R1 zwe",     {31'd0, zflag_we}, 32'd0);
    check("R1 z_flag",  {31'd0, z_flag},   32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      vec_t t;
      t = VECS[v];
      regs[t.r1] = t.base;
      if (t.is_reg) regs[t.r2] = t.sel;
      // R2 / R3 expected address and bit
      ea  = t.is_reg ? t.base : t.base + {{16{t.disp[15]}}, t.disp};
      eb  = t.is_reg ? t.sel[2:0] : t.ibit;
      ewb = t.init | (8'h01 << eb);
      mem[ea[7:0]] = t.init;
      wait_cur = int'(t.wt);
      clear_mon(ea);
      if (t.is_reg) issue(hw_reg(t.r2, t.r1), 16'h00E0);
      else          issue(hw_imm(t.ibit, t.r1), t.disp);
      wait_idle(cyc);
      check(t.is_reg ? "R3 address" : "R2 address", addr_bad, 0);
      check("R5 memory byte", {24'd0, mem[ea[7:0]]}, {24'd0, ewb});
      check("R5 write data", {24'd0, last_wdata}, {24'd0, ewb});
      check("R4 z_flag", {31'd0, z_flag}, {31'd0, ~t.init[eb]});
      check("R4 zwe pulses", zwe_cnt, 1);
      check("R7 one read", rd_cnt, 1);
      check("R7 one write", wr_cnt, 1);
      check("R7 order", order_bad, 0);
      check("R6 busy cycles", cyc, 2 + 2 * int'(t.wt));
    end

    // R9 flag holds while idle
    z_keep = z_flag;
    repeat (5) @(negedge clk);
    check("R9 hold idle", {31'd0, z_flag}, {31'd0, z_keep});

    // R8 bad immediate prefix ignored
    wait_cur = 0;
    clear_mon(32'hFFFF_FFFF);
    regs[6] = 32'h0000_0030;
    issue({2'b01, 3'd2, 6'b111110, 5'd6}, 16'h0000);
    check("R8 bad prefix busy", {31'd0, busy}, 32'd0);
    @(negedge clk);
    check("R8 bad prefix access", rd_cnt + wr_cnt, 0);
    // R8 register form with wrong extension halfword
    issue(hw_reg(5'd0, 5'd6), 16'h00E1);
    @(negedge clk);
    check("R8 bad ext access", rd_cnt + wr_cnt + zwe_cnt, 0);
    check("R9 hold after bad issue", {31'd0, z_flag}, {31'd0, z_keep});

    // R8 issue during busy is dropped
    regs[20] = 32'h0000_0099;
    regs[21] = 32'h0;
    mem[8'h99] = 8'h00;
    regs[3]  = 32'h0000_00A0;
    mem[8'hA0] = 8'h01;
    wait_cur = 1;
    clear_mon(32'h0000_00A0);
    issue(hw_imm(3'd0, 5'd3), 16'h0000);
    issue(hw_reg(5'd21, 5'd20), 16'h00E0);
    wait_idle(cyc);
    repeat (3) @(negedge clk);
    check("R8 dropped target byte", {24'd0, mem[8'h99]}, 32'd0);
    check("R8 single write", wr_cnt, 1);
    check("R4 bit already set", {31'd0, z_flag}, 32'd0);
    check("R8 stays idle", {31'd0, busy}, 32'd0);

    // R1 reset mid-sequence clears state
    wait_cur = 3;
    clear_mon(32'h0000_00A0);
    issue(hw_imm(3'd4, 5'd3), 16'h0000);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid busy", {31'd0, busy}, 32'd0);
    check("R1 reset mid z", {31'd0, z_flag}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule